// File: doc/BRIEF.md
# Strobe-Handshake Processor Bus Slave

This block is a synchronous slave port that lets a processor with an asynchronous strobe bus reach a small internal register file and a 32-bit-wide word memory. Every processor input is registered on the system clock. The strobe is edge-detected from the registered copies. When the strobe falls while chip enable is asserted, the address is decoded, the access is carried out, and an acknowledge is raised after a delay that depends on the kind of access. The acknowledge is held until the strobe is seen to rise again. The processor then starts its next cycle.

The bus works in one of two widths. In 32-bit mode a memory word moves in one access. In 16-bit mode each memory word takes two consecutive accesses, and an internal half-word toggle tracks which half comes next. The first access always carries the low half. A write is committed to memory only on the second access. A read captures the whole word on the first access and serves the high half from that capture on the second access, which is therefore faster. Registers are 16 bits wide and behave the same in both modes: only the low word of the data bus is used.

The port is a strobe/acknowledge handshake. The acknowledge is its only flow control, and the processor must hold the strobe low until it sees the acknowledge.

Top module: `shp_bus_slave`

## Requirements
- R1: After reset the acknowledge is low, the half-word toggle selects the low half, and every register reads back as zero.
- R2: A register write stores data bits [15:0]. The acknowledge is high after the 2nd rising clock edge, counting the first edge that samples the strobe low as edge 1.
- R3: Once the acknowledge is high, it stays high after the first edge that samples the strobe high and is low after the second.
- R4: A register read returns the register in bits [15:0] and zeros in bits [31:16]. The acknowledge is high after edge 3.
- R5: In 32-bit mode, register accesses have the same timing and use only bits [15:0]. Data bits [31:16] of a write are ignored.
- R6: A 16-bit mode memory write whose toggle selects the low half only holds data bits [15:0] and leaves memory unchanged. The next one writes {its bits [15:0], held half} at its own address. Both are acknowledged after edge 2.
- R7: A 16-bit mode memory read whose toggle selects the low half captures the whole word and returns its bits [15:0], acknowledged after edge 5. The next one returns the captured bits [31:16], even if memory has changed since, acknowledged after edge 3.
- R8: In 32-bit mode a memory write commits the full 32-bit word in one access, acknowledged after edge 2. A memory read returns the full word, acknowledged after edge 5.
- R9: Address bit 4 (the top address bit) selects memory when 1 and registers when 0. The low bits index the selected array.
- R10: The read data bus is all zeros unless chip enable is high and read/write is high (1 = read).
- R11: A strobe cycle while chip enable is low is ignored: no acknowledge and no write.
- R12: Register accesses and 32-bit mode accesses leave the half-word toggle unchanged. A completed pair of 16-bit mode memory accesses returns it to the low half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cs | input | 1 | Chip enable, active high |
| bus_stb_n | input | 1 | Access strobe, active low |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_wide | input | 1 | 1 = 32-bit bus mode, 0 = 16-bit bus mode |
| bus_addr | input | 5 | Address; top bit selects memory |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero unless selected for read |
| bus_ack | output | 1 | Data acknowledge |

## Verification
Each result is due a fixed number of rising edges after the strobe is first sampled low: 2 for writes, 3 for register reads and second-half memory reads, and 5 for first-half and 32-bit memory reads. The acknowledge falls on the second edge after the strobe is sampled high. The bench drives the strobe on a falling clock edge and samples on every later falling edge. It records the first edge index at which the acknowledge is seen high and compares that index with the expected count, so an acknowledge one edge early or late is reported. Read data is checked while the acknowledge is high. Memory contents that must not change yet are read back through 32-bit mode accesses, which do not move the toggle.

// File: rtl/shp_pkg.sv
package shp_pkg;
  typedef enum logic [3:0] {
    ACC_NONE,
    ACC_REG_WR,
    ACC_REG_RD,
    ACC_MEM_WR_LO,
    ACC_MEM_WR_HI,
    ACC_MEM_WR32,
    ACC_MEM_RD_LO,
    ACC_MEM_RD_HI,
    ACC_MEM_RD32
  } acc_kind_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_HOLD
  } hs_state_t;

  // extra clocks beyond the write latency
  localparam int unsigned EXTRA_FAST = 1;
  localparam int unsigned EXTRA_SLOW = 3;
endpackage

// File: rtl/shp_sync.sv
module shp_sync #(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          stb_n,
  input  logic          rnw,
  input  logic          wide,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          rnw_q,
  output logic          wide_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic          fall,
  output logic          rise
);
  logic cs_q, stb_q, stb_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q     <= 1'b0;
      stb_q    <= 1'b1;
      stb_prev <= 1'b1;
      rnw_q    <= 1'b1;
      wide_q   <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
    end else begin
      cs_q     <= cs;
      stb_q    <= stb_n;
      stb_prev <= stb_q;
      rnw_q    <= rnw;
      wide_q   <= wide;
      addr_q   <= addr;
      wdata_q  <= wdata;
    end
  end

  assign fall = cs_q & stb_prev & ~stb_q;
  assign rise = ~stb_prev & stb_q;
endmodule

// File: rtl/shp_ctrl.sv
module shp_ctrl
  import shp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      fall,
  input  logic      rise,
  input  logic      rnw,
  input  logic      wide,
  input  logic      is_mem,
  output acc_kind_t kind,
  output logic      ack
);
  hs_state_t   state;
  logic [1:0]  cnt;
  logic        half;
  int unsigned extra;

  always_comb begin
    kind = ACC_NONE;
    if (fall && state == ST_IDLE) begin
      if (!is_mem)   kind = rnw ? ACC_REG_RD : ACC_REG_WR;
      else if (wide) kind = rnw ? ACC_MEM_RD32 : ACC_MEM_WR32;
      else if (rnw)  kind = half ? ACC_MEM_RD_HI : ACC_MEM_RD_LO;
      else           kind = half ? ACC_MEM_WR_HI : ACC_MEM_WR_LO;
    end
  end

  always_comb begin
    case (kind)
      ACC_REG_RD, ACC_MEM_RD_HI:   extra = EXTRA_FAST;
      ACC_MEM_RD_LO, ACC_MEM_RD32: extra = EXTRA_SLOW;
      default:                     extra = 0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      ack   <= 1'b0;
    end else if (rise) begin
      state <= ST_IDLE;
      ack   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (kind != ACC_NONE) begin
          if (extra == 0) begin
            ack   <= 1'b1;
            state <= ST_HOLD;
          end else begin
            cnt   <= 2'(extra - 1);
            state <= ST_WAIT;
          end
        end
        ST_WAIT: if (cnt == 0) begin
          ack   <= 1'b1;
          state <= ST_HOLD;
        end else begin
          cnt <= cnt - 2'd1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half <= 1'b0;
    else if (kind == ACC_MEM_WR_LO || kind == ACC_MEM_RD_LO) half <= 1'b1;
    else if (kind == ACC_MEM_WR_HI || kind == ACC_MEM_RD_HI) half <= 1'b0;
  end

  assert_wr_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == ACC_REG_WR) |=> ack);
  assert_rd_late_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == ACC_REG_RD) |=> !ack);
  assert_ack_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !ack);
  assert_toggle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == ACC_REG_WR || kind == ACC_REG_RD || kind == ACC_MEM_WR32 || kind == ACC_MEM_RD32)
    |=> $stable(half));
  assert_first_rd_slow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == ACC_MEM_RD_LO && !rise) |=> !ack);
endmodule

// File: rtl/shp_store.sv
module shp_store
  import shp_pkg::*;
#(
  parameter int REG_AW = 3,
  parameter int MEM_AW = 4,
  parameter int DW     = 32,
  localparam int HW    = DW / 2,
  localparam int REG_N = 1 << REG_AW,
  localparam int MEM_N = 1 << MEM_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  acc_kind_t         kind,
  input  logic [REG_AW-1:0] reg_idx,
  input  logic [MEM_AW-1:0] mem_idx,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata
);
  logic [HW-1:0] regs [REG_N];
  logic [DW-1:0] mem  [MEM_N];
  logic [HW-1:0] wr_hold;
  logic [DW-1:0] rd_cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < REG_N; i++) regs[i] <= '0;
      wr_hold <= '0;
      rd_cap  <= '0;
      rdata   <= '0;
    end else begin
      case (kind)
        ACC_REG_WR:    regs[reg_idx] <= wdata[HW-1:0];
        ACC_REG_RD:    rdata <= {{HW{1'b0}}, regs[reg_idx]};
        ACC_MEM_WR_LO: wr_hold <= wdata[HW-1:0];
        ACC_MEM_RD_LO: begin
          rd_cap <= mem[mem_idx];
          rdata  <= {{HW{1'b0}}, mem[mem_idx][HW-1:0]};
        end
        ACC_MEM_RD_HI: rdata <= {{HW{1'b0}}, rd_cap[DW-1:HW]};
        ACC_MEM_RD32:  rdata <= mem[mem_idx];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (kind == ACC_MEM_WR_HI) mem[mem_idx] <= {wdata[HW-1:0], wr_hold};
    else if (kind == ACC_MEM_WR32) mem[mem_idx] <= wdata;
  end
endmodule

// File: rtl/shp_bus_slave.sv
module shp_bus_slave
  import shp_pkg::*;
#(
  parameter int REG_AW = 3,
  parameter int MEM_AW = 4,
  parameter int DW     = 32,
  localparam int AW    = ((REG_AW > MEM_AW) ? REG_AW : MEM_AW) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_cs,
  input  logic          bus_stb_n,
  input  logic          bus_rnw,
  input  logic          bus_wide,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_ack
);
  logic          rnw_q, wide_q, fall, rise;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  acc_kind_t     kind;

  shp_sync #(.AW(AW), .DW(DW)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs(bus_cs), .stb_n(bus_stb_n), .rnw(bus_rnw),
    .wide(bus_wide), .addr(bus_addr), .wdata(bus_wdata), .rnw_q(rnw_q),
    .wide_q(wide_q), .addr_q(addr_q), .wdata_q(wdata_q), .fall(fall), .rise(rise)
  );

  shp_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .fall(fall), .rise(rise), .rnw(rnw_q),
    .wide(wide_q), .is_mem(addr_q[AW-1]), .kind(kind), .ack(bus_ack)
  );

  shp_store #(.REG_AW(REG_AW), .MEM_AW(MEM_AW), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .kind(kind), .reg_idx(addr_q[REG_AW-1:0]),
    .mem_idx(addr_q[MEM_AW-1:0]), .wdata(wdata_q), .rdata(rdata_q)
  );

  assign bus_rdata = (bus_cs && bus_rnw) ? rdata_q : '0;
endmodule

// File: tb/shp_bus_slave_bench.sv
module shp_bus_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_cs = 1'b0, bus_stb_n = 1'b1, bus_rnw = 1'b1, bus_wide = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ack;
  int          errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shp_bus_slave u_shp_bus_slave (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_stb_n(bus_stb_n),
    .bus_rnw(bus_rnw), .bus_wide(bus_wide), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one handshake cycle; latency counted in edges from the first strobe-low sample
  task automatic access(input bit wide, input bit rnw, input logic [4:0] addr,
                        input logic [31:0] wd, input int exp_lat,
                        input logic [31:0] exp_rd, input string req);
    int lat = 0;
    @(negedge clk);
    bus_cs = 1'b1; bus_rnw = rnw; bus_wide = wide; bus_addr = addr; bus_wdata = wd;
    @(negedge clk);
    bus_stb_n = 1'b0;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (bus_ack && lat == 0) lat = k;
    end
    check(lat == exp_lat, req, "ack latency", lat, exp_lat);
    if (rnw) check(bus_rdata == exp_rd, req, "read data", bus_rdata, exp_rd);
    bus_stb_n = 1'b1;
    @(negedge clk);
    check(bus_ack == 1'b1, "R3", "ack after first high sample", bus_ack, 1);
    @(negedge clk);
    check(bus_ack == 1'b0, "R3", "ack after second high sample", bus_ack, 0);
    bus_cs = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check(bus_ack == 1'b0, "R1", "ack at reset", bus_ack, 0);
    access(1'b0, 1'b1, 5'h03, 32'h0, 3, 32'h0, "R1");
    // toggle at low half: a first 16-bit read is the slow one
    access(1'b1, 1'b0, 5'h11, 32'hCAFE_F00D, 2, 32'h0, "R8");
    access(1'b0, 1'b1, 5'h11, 32'h0, 5, 32'h0000_F00D, "R1");
    access(1'b0, 1'b1, 5'h11, 32'h0, 3, 32'h0000_CAFE, "R7");
  endtask

  task automatic t_registers();
    access(1'b0, 1'b0, 5'h02, 32'hFFFF_A5A5, 2, 32'h0, "R2");
    access(1'b0, 1'b1, 5'h02, 32'h0, 3, 32'h0000_A5A5, "R4");
    access(1'b1, 1'b0, 5'h05, 32'hDEAD_1234, 2, 32'h0, "R5");
    access(1'b1, 1'b1, 5'h05, 32'h0, 3, 32'h0000_1234, "R5");
  endtask

  task automatic t_region();
    access(1'b1, 1'b0, 5'h12, 32'h1111_2222, 2, 32'h0, "R9");
    access(1'b0, 1'b1, 5'h02, 32'h0, 3, 32'h0000_A5A5, "R9");
    access(1'b1, 1'b1, 5'h12, 32'h0, 5, 32'h1111_2222, "R8");
  endtask

  task automatic t_mem_write16();
    access(1'b1, 1'b0, 5'h15, 32'h0, 2, 32'h0, "R8");
    access(1'b0, 1'b0, 5'h15, 32'hAAAA_3333, 2, 32'h0, "R6");
    access(1'b1, 1'b1, 5'h15, 32'h0, 5, 32'h0, "R6");
    access(1'b0, 1'b0, 5'h15, 32'hBBBB_4444, 2, 32'h0, "R6");
    access(1'b1, 1'b1, 5'h15, 32'h0, 5, 32'h4444_3333, "R6");
  endtask

  task automatic t_mem_read16();
    access(1'b0, 1'b1, 5'h15, 32'h0, 5, 32'h0000_3333, "R7");
    access(1'b1, 1'b0, 5'h15, 32'h9999_8888, 2, 32'h0, "R12");
    access(1'b0, 1'b1, 5'h15, 32'h0, 3, 32'h0000_4444, "R7");
    access(1'b0, 1'b1, 5'h15, 32'h0, 5, 32'h0000_8888, "R12");
    access(1'b0, 1'b1, 5'h05, 32'h0, 3, 32'h0000_1234, "R12");
    access(1'b0, 1'b1, 5'h15, 32'h0, 3, 32'h0000_9999, "R12");
  endtask

  task automatic t_rdata_gate();
    @(negedge clk);
    bus_cs = 1'b0; bus_rnw = 1'b1;
    @(negedge clk);
    check(bus_rdata == 32'h0, "R10", "rdata with cs low", bus_rdata, 0);
    bus_cs = 1'b1; bus_rnw = 1'b0;
    @(negedge clk);
    check(bus_rdata == 32'h0, "R10", "rdata during write", bus_rdata, 0);
    bus_cs = 1'b0;
  endtask

  task automatic t_no_select();
    int seen = 0;
    @(negedge clk);
    bus_cs = 1'b0; bus_rnw = 1'b0; bus_wide = 1'b0; bus_addr = 5'h02; bus_wdata = 32'h0000_7777;
    @(negedge clk);
    bus_stb_n = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (bus_ack) seen = 1;
    end
    check(seen == 0, "R11", "ack without chip enable", seen, 0);
    bus_stb_n = 1'b1;
    repeat (3) @(negedge clk);
    access(1'b0, 1'b1, 5'h02, 32'h0, 3, 32'h0000_A5A5, "R11");
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_registers();
    t_region();
    t_mem_write16();
    t_mem_read16();
    t_rdata_gate();
    t_no_select();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule